// File: doc/BRIEF.md
# Target Hold-Off and Retry Controller

This block is the target-side flow control for host-initiated direct accesses that a bridge forwards to its local bus. It sits between the host-facing target logic, a posted write FIFO, a read FIFO and the local bus sequencer. It decides, one data phase at a time, whether the host sees a completed phase (`tgt_ready`), a stalled phase, or a retry (`tgt_retry`). The FIFOs and the sequencer appear only as occupancy levels and simple request handshakes. Bus protocol signalling is left to the surrounding logic.

For writes, the block completes a data phase whenever the write FIFO has room. When the FIFO is full, a mode input picks one of two responses: retry at once, or stall until room appears. For reads, it first asks the local sequencer for data and withholds ready until the read FIFO holds a longword. Memory-space reads ask for a 16-longword prefetch, or an open-ended one when continuous prefetch is enabled. I/O-space reads ask for exactly one longword per data phase. A wait counter runs during every stalled cycle. When it reaches a programmed limit before ready can be given, the block retries and abandons the access. Read data that is still buffered when a read transaction ends or is retried is discarded.

The controller is a four-state machine:
- `ST_IDLE`: no transaction is open.
- `ST_WR_XFER`: a write transaction is open.
- `ST_RD_ISSUE`: a read needs a local request.
- `ST_RD_FETCH`: a request is outstanding or data is buffered.

The transitions are:
- `ST_IDLE` to `ST_WR_XFER` or `ST_RD_ISSUE` on `tx_start`, chosen by `tx_write`.
- `ST_RD_ISSUE` to `ST_RD_FETCH` when the sequencer accepts a request.
- `ST_RD_FETCH` back to `ST_RD_ISSUE` when the last longword of a bounded request is consumed.
- Any open state back to `ST_IDLE` on `tx_end` or on a retry.

Top module: `tgt_holdoff_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `tgt_ready`, `tgt_retry`, `wf_push`, `rf_pop`, `lrq_valid` and `rd_discard` are all 0.
- R2: During an open write transaction, a data phase (`tx_beat`=1) with `wf_level` below the write FIFO depth (32) gets `tgt_ready`=1 and `wf_push`=1 in the same cycle.
- R3: A write data phase that meets a full FIFO (`wf_level`=32) while `cfg_full_retry`=1 gets `tgt_retry`=1 in the same cycle, with no push. The transaction is then closed: `tgt_ready` and `tgt_retry` are never 1 together, and later phases get no ready until a new `tx_start`.
- R4: With `cfg_full_retry`=0, a write phase that meets a full FIFO holds `tgt_ready` at 0. It completes in the first cycle in which `wf_level` drops below 32, provided the wait limit has not yet been reached.
- R5: A read data phase gets `tgt_ready`=1, together with `rf_pop`=1, only after a local request has been accepted and only in a cycle with `rf_level`>0. Ready stays 0 while the read FIFO is empty.
- R6: The first read phase of a memory-space transaction (`tx_io`=0) raises `lrq_valid` with `lrq_len`=16. `lrq_cont` equals the `cfg_cont_pf` value sampled at `tx_start`. With `lrq_cont`=0, a new request is raised after 16 longwords are consumed. With `lrq_cont`=1, no further request is raised for the rest of the transaction.
- R7: In an I/O-space read (`tx_io`=1), every data phase raises its own request with `lrq_len`=1 and `lrq_cont`=0. It takes no buffered data until that request has been accepted.
- R8: The wait counter is cleared at transaction start and at every ready. It counts each cycle in which a data phase is pending without ready. `tgt_retry` is asserted in the stalled cycle in which it equals `cfg_wait_limit`, so that is the (L+1)-th consecutive stalled cycle for a limit L.
- R9: `rd_discard` pulses when an open read transaction ends (`tx_end`) or is retried. After a read retry, the next read transaction starts with a fresh local request and ignores any data still reported in the read FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_full_retry | input | 1 | 1: retry on a full write FIFO; 0: stall |
| cfg_cont_pf | input | 1 | 1: memory reads use continuous prefetch |
| cfg_wait_limit | input | TMR_W | Stalled cycles allowed before retry |
| tx_start | input | 1 | Pulse: a host transaction begins |
| tx_write | input | 1 | Direction of the starting transaction (1 = write) |
| tx_io | input | 1 | Space of the starting transaction (1 = I/O, 0 = memory) |
| tx_beat | input | 1 | A data phase is pending |
| tx_end | input | 1 | Pulse: the host transaction ends |
| tgt_ready | output | 1 | Data phase completes this cycle |
| tgt_retry | output | 1 | Retry; the transaction is abandoned |
| wf_level | input | WLW | Write FIFO occupancy in longwords |
| wf_push | output | 1 | Write the current phase into the write FIFO |
| rf_level | input | RLW | Read FIFO occupancy in longwords |
| rf_pop | output | 1 | Take one longword from the read FIFO |
| lrq_valid | output | 1 | Local read request pending |
| lrq_ready | input | 1 | Sequencer accepts the request |
| lrq_len | output | RLW | Longwords requested (1 or 16) |
| lrq_cont | output | 1 | Request is open-ended prefetch |
| rd_discard | output | 1 | Drop buffered and in-flight read data |

## Verification
The bound checker watches these properties on every cycle:
- A push only happens with ready and room in the write FIFO.
- A pop only happens with ready and buffered data.
- Ready and retry never coincide, and retry closes the transaction.
- Every local request has one of the two legal shapes.
- No data phase stalls for more cycles than the wait limit allows.

Some behaviours need a sequence of cycles, so only the bench's scenarios can show them:
- The exact cycle of completion or retry for each mode and limit.
- The refill request after 16 consumed longwords.
- The absence of refills under continuous prefetch.
- The per-phase requests of I/O reads.
- The counter restarting after each ready.
- The fresh start after a read retry.

// File: rtl/thr_pkg.sv
package thr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WR_XFER  = 2'd1,
        ST_RD_ISSUE = 2'd2,
        ST_RD_FETCH = 2'd3
    } thr_state_e;

endpackage

// File: rtl/thr_wait_timer.sv
module thr_wait_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             hold,
    input  logic [TMR_W-1:0] limit,
    output logic             expired
);

    logic [TMR_W-1:0] cnt_q;

    // Reaching or passing the limit counts as expiry, so a limit lowered
    // mid-transaction cannot let the counter run past it and wrap.
    assign expired = (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (hold && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/thr_read_credit.sv
module thr_read_credit #(
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic [LW-1:0] load_len,
    input  logic          load_cont,
    input  logic          take,
    output logic          last
);

    logic [LW-1:0] left_q;
    logic          open_q;

    // The final longword of a bounded request: consuming it means the
    // next data phase needs a new local request.
    assign last = !open_q && (left_q == LW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            open_q <= 1'b0;
        end else if (clear) begin
            left_q <= '0;
            open_q <= 1'b0;
        end else if (load) begin
            left_q <= load_len;
            open_q <= load_cont;
        end else if (take && !open_q && (left_q != '0)) begin
            left_q <= left_q - 1'b1;
        end
    end

endmodule

// File: rtl/tgt_holdoff_ctrl.sv
module tgt_holdoff_ctrl
    import thr_pkg::*;
#(
    parameter  int WF_DEPTH = 32,
    parameter  int RF_DEPTH = 16,
    parameter  int TMR_W    = 8,
    localparam int WLW      = $clog2(WF_DEPTH + 1),
    localparam int RLW      = $clog2(RF_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_full_retry,
    input  logic             cfg_cont_pf,
    input  logic [TMR_W-1:0] cfg_wait_limit,
    input  logic             tx_start,
    input  logic             tx_write,
    input  logic             tx_io,
    input  logic             tx_beat,
    input  logic             tx_end,
    output logic             tgt_ready,
    output logic             tgt_retry,
    input  logic [WLW-1:0]   wf_level,
    output logic             wf_push,
    input  logic [RLW-1:0]   rf_level,
    output logic             rf_pop,
    output logic             lrq_valid,
    input  logic             lrq_ready,
    output logic [RLW-1:0]   lrq_len,
    output logic             lrq_cont,
    output logic             rd_discard
);

    thr_state_e st_q, st_nx;

    logic io_q;
    logic cont_q;
    logic hold;
    logic expired;
    logic pf_last;
    logic wf_full;
    logic rf_empty;
    logic phase_live;
    logic tmr_clear;
    logic credit_clear;
    logic credit_load;

    assign wf_full    = (wf_level >= WLW'(WF_DEPTH));
    assign rf_empty   = (rf_level == '0);
    // A data phase counts only while a transaction is open and not ending.
    assign phase_live = tx_beat && !tx_end && (st_q != ST_IDLE);

    // Transaction attributes are sampled once, at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_q   <= 1'b0;
            cont_q <= 1'b0;
        end else if ((st_q == ST_IDLE) && tx_start) begin
            io_q   <= tx_io;
            cont_q <= cfg_cont_pf;
        end
    end

    // Output decode: ready, retry and the FIFO/sequencer handshakes.
    always_comb begin
        hold       = 1'b0;
        tgt_ready  = 1'b0;
        tgt_retry  = 1'b0;
        wf_push    = 1'b0;
        rf_pop     = 1'b0;
        lrq_valid  = 1'b0;
        rd_discard = 1'b0;
        lrq_len    = io_q ? RLW'(1) : RLW'(RF_DEPTH);
        lrq_cont   = !io_q && cont_q;
        unique case (st_q)
            ST_IDLE: begin
            end
            ST_WR_XFER: begin
                if (phase_live) begin
                    if (!wf_full) begin
                        tgt_ready = 1'b1;
                        wf_push   = 1'b1;
                    end else if (cfg_full_retry) begin
                        tgt_retry = 1'b1;
                    end else begin
                        hold = 1'b1;
                    end
                end
            end
            ST_RD_ISSUE: begin
                if (phase_live) begin
                    hold      = 1'b1;
                    lrq_valid = !expired;
                end
            end
            ST_RD_FETCH: begin
                if (phase_live) begin
                    if (!rf_empty) begin
                        tgt_ready = 1'b1;
                        rf_pop    = 1'b1;
                    end else begin
                        hold = 1'b1;
                    end
                end
            end
            default: begin
            end
        endcase
        if (hold && expired) begin
            tgt_retry = 1'b1;
        end
        if (((st_q == ST_RD_ISSUE) || (st_q == ST_RD_FETCH)) &&
            (tx_end || tgt_retry)) begin
            rd_discard = 1'b1;
        end
    end

    // Next-state decode.
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (tx_start) begin
                    st_nx = tx_write ? ST_WR_XFER : ST_RD_ISSUE;
                end
            end
            ST_WR_XFER: begin
                if (tx_end || tgt_retry) begin
                    st_nx = ST_IDLE;
                end
            end
            ST_RD_ISSUE: begin
                if (tx_end || tgt_retry) begin
                    st_nx = ST_IDLE;
                end else if (lrq_valid && lrq_ready) begin
                    st_nx = ST_RD_FETCH;
                end
            end
            ST_RD_FETCH: begin
                if (tx_end || tgt_retry) begin
                    st_nx = ST_IDLE;
                end else if (rf_pop && pf_last) begin
                    st_nx = ST_RD_ISSUE;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    assign tmr_clear    = (st_q == ST_IDLE) || tgt_ready;
    assign credit_clear = (st_q == ST_IDLE) || rd_discard;
    assign credit_load  = lrq_valid && lrq_ready;

    thr_wait_timer #(
        .TMR_W (TMR_W)
    ) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .hold    (hold),
        .limit   (cfg_wait_limit),
        .expired (expired)
    );

    thr_read_credit #(
        .LW (RLW)
    ) u_credit (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (credit_clear),
        .load      (credit_load),
        .load_len  (lrq_len),
        .load_cont (lrq_cont),
        .take      (rf_pop),
        .last      (pf_last)
    );

endmodule

// File: rtl/thr_chk.sv
module thr_chk #(
    parameter  int WF_DEPTH = 32,
    parameter  int RF_DEPTH = 16,
    parameter  int TMR_W    = 8,
    localparam int WLW      = $clog2(WF_DEPTH + 1),
    localparam int RLW      = $clog2(RF_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TMR_W-1:0] cfg_wait_limit,
    input logic             tx_start,
    input logic             tx_beat,
    input logic             tx_end,
    input logic             tgt_ready,
    input logic             tgt_retry,
    input logic [WLW-1:0]   wf_level,
    input logic             wf_push,
    input logic [RLW-1:0]   rf_level,
    input logic             rf_pop,
    input logic             lrq_valid,
    input logic [RLW-1:0]   lrq_len,
    input logic             lrq_cont
);

    logic           open_q;
    logic [TMR_W:0] stall_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q  <= 1'b0;
            stall_q <= '0;
        end else begin
            if (tx_start) begin
                open_q <= 1'b1;
            end else if (tx_end || tgt_retry) begin
                open_q <= 1'b0;
            end
            if (tx_start || tgt_ready || tgt_retry || !open_q) begin
                stall_q <= '0;
            end else if (tx_beat && !tx_end) begin
                stall_q <= stall_q + 1'b1;
            end
        end
    end

    // R2
    push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wf_push |-> (tgt_ready && (wf_level < WLW'(WF_DEPTH))));

    // R5
    pop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_pop |-> (tgt_ready && (rf_level != '0)));

    // R3
    ready_retry_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tgt_ready && tgt_retry));

    // R3
    retry_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_retry |=> !tgt_ready);

    // R7
    req_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lrq_valid |-> ((lrq_len == RLW'(1)) || (lrq_len == RLW'(RF_DEPTH))));

    // R6
    cont_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lrq_valid && lrq_cont) |-> (lrq_len == RLW'(RF_DEPTH)));

    // R8
    always @(posedge clk) begin
        if (rst_n && open_q) begin
            stall_window_chk: assert (stall_q <= {1'b0, cfg_wait_limit});
        end
    end

endmodule

bind tgt_holdoff_ctrl thr_chk #(
    .WF_DEPTH (WF_DEPTH),
    .RF_DEPTH (RF_DEPTH),
    .TMR_W    (TMR_W)
) u_thr_chk (.*);

// File: tb/tgt_holdoff_ctrl_bench.sv
module tgt_holdoff_ctrl_bench;

    localparam int WF_DEPTH = 32;
    localparam int RF_DEPTH = 16;
    localparam int TMR_W    = 8;
    localparam int WLW      = $clog2(WF_DEPTH + 1);
    localparam int RLW      = $clog2(RF_DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cfg_full_retry, cfg_cont_pf;
    logic [TMR_W-1:0] cfg_wait_limit;
    logic             tx_start, tx_write, tx_io, tx_beat, tx_end;
    logic             tgt_ready, tgt_retry;
    logic [WLW-1:0]   wf_level;
    logic             wf_push;
    logic [RLW-1:0]   rf_level;
    logic             rf_pop;
    logic             lrq_valid, lrq_ready;
    logic [RLW-1:0]   lrq_len;
    logic             lrq_cont, rd_discard;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tgt_holdoff_ctrl #(
        .WF_DEPTH (WF_DEPTH),
        .RF_DEPTH (RF_DEPTH),
        .TMR_W    (TMR_W)
    ) u_tgt_holdoff_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_full_retry (cfg_full_retry),
        .cfg_cont_pf    (cfg_cont_pf),
        .cfg_wait_limit (cfg_wait_limit),
        .tx_start       (tx_start),
        .tx_write       (tx_write),
        .tx_io          (tx_io),
        .tx_beat        (tx_beat),
        .tx_end         (tx_end),
        .tgt_ready      (tgt_ready),
        .tgt_retry      (tgt_retry),
        .wf_level       (wf_level),
        .wf_push        (wf_push),
        .rf_level       (rf_level),
        .rf_pop         (rf_pop),
        .lrq_valid      (lrq_valid),
        .lrq_ready      (lrq_ready),
        .lrq_len        (lrq_len),
        .lrq_cont       (lrq_cont),
        .rd_discard     (rd_discard)
    );

    // Write full-FIFO scenarios: mode, limit, cycles until room appears,
    // expected outcome (1 = retry) and the phase cycle it lands in.
    typedef struct packed {
        logic       mode;
        logic [7:0] lim;
        logic [7:0] drain;
        logic       exp_retry;
        logic [7:0] exp_cyc;
    } wvec_t;

    localparam int VEC_N = 7;
    localparam wvec_t WV [VEC_N] = '{
        '{1'b1, 8'd5, 8'd3, 1'b1, 8'd0},
        '{1'b0, 8'd5, 8'd0, 1'b0, 8'd0},
        '{1'b0, 8'd5, 8'd3, 1'b0, 8'd3},
        '{1'b0, 8'd5, 8'd5, 1'b0, 8'd5},
        '{1'b0, 8'd5, 8'd6, 1'b1, 8'd5},
        '{1'b0, 8'd0, 8'd1, 1'b1, 8'd0},
        '{1'b0, 8'd2, 8'd9, 1'b1, 8'd2}
    };

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic start_tx(input logic wr, input logic io);
        tx_start = 1'b1;
        tx_write = wr;
        tx_io    = io;
        tick();
        tx_start = 1'b0;
        tx_write = 1'b0;
        tx_io    = 1'b0;
    endtask

    task automatic end_tx();
        tx_beat = 1'b0;
        tx_end  = 1'b1;
        tick();
        tx_end  = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int k;
        int cnt_a;
        int cnt_b;
        bit got;
        logic kind;
        logic pushed;
        rst_n = 1'b0;
        cfg_full_retry = 1'b0;
        cfg_cont_pf = 1'b0;
        cfg_wait_limit = 8'd200;
        tx_start = 1'b0;
        tx_write = 1'b0;
        tx_io = 1'b0;
        tx_beat = 1'b0;
        tx_end = 1'b0;
        wf_level = '0;
        rf_level = '0;
        lrq_ready = 1'b0;
        repeat (3) tick();
        @(negedge clk);
        check("R1 reset ready", tgt_ready, 0);
        check("R1 reset retry", tgt_retry, 0);
        check("R1 reset handshakes",
              {wf_push, rf_pop, lrq_valid, rd_discard}, 0);
        tick();
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset outputs",
              {tgt_ready, tgt_retry, wf_push, rf_pop, lrq_valid, rd_discard}, 0);
        tick();

        // Full write FIFO scenarios from the table (R2 R3 R4 R8).
        for (int i = 0; i < VEC_N; i++) begin
            cfg_full_retry = WV[i].mode;
            cfg_wait_limit = WV[i].lim;
            start_tx(1'b1, 1'b0);
            tx_beat = 1'b1;
            k = 0;
            got = 1'b0;
            kind = 1'b0;
            pushed = 1'b0;
            while (!got && k < 40) begin
                wf_level = (k >= int'(WV[i].drain)) ? WLW'(31) : WLW'(32);
                @(negedge clk);
                if (tgt_ready || tgt_retry) begin
                    got = 1'b1;
                    kind = tgt_retry;
                    pushed = wf_push;
                end else begin
                    tick();
                    k++;
                end
            end
            check($sformatf("R3 R4 R8 vector %0d outcome", i), kind, WV[i].exp_retry);
            check($sformatf("R4 R8 vector %0d cycle", i), k, WV[i].exp_cyc);
            check($sformatf("R2 vector %0d push", i), pushed, !WV[i].exp_retry);
            tick();
            end_tx();
            wf_level = '0;
        end

        // R3: phases after a full-FIFO retry are not completed.
        cfg_full_retry = 1'b1;
        cfg_wait_limit = 8'd200;
        start_tx(1'b1, 1'b0);
        tx_beat = 1'b1;
        wf_level = WLW'(32);
        @(negedge clk);
        check("R3 immediate retry", tgt_retry, 1);
        tick();
        wf_level = WLW'(10);
        cnt_a = 0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            cnt_a += int'(tgt_ready) + int'(wf_push);
            tick();
        end
        check("R3 ignored phases after retry", cnt_a, 0);
        end_tx();
        cfg_full_retry = 1'b0;

        // R8: counter restarts after each ready within a transaction.
        cfg_wait_limit = 8'd2;
        start_tx(1'b1, 1'b0);
        tx_beat = 1'b1;
        cnt_a = 0;
        cnt_b = 0;
        for (int ph = 0; ph < 2; ph++) begin
            for (int c = 0; c < 3; c++) begin
                wf_level = (c < 2) ? WLW'(32) : WLW'(31);
                @(negedge clk);
                if (tgt_ready != (c == 2)) cnt_a++;
                cnt_b += int'(tgt_retry);
                tick();
            end
        end
        check("R8 restart ready pattern mismatches", cnt_a, 0);
        check("R8 restart no retry", cnt_b, 0);
        end_tx();
        wf_level = '0;
        cfg_wait_limit = 8'd200;

        // Memory read, bounded prefetch (R5 R6 R9).
        start_tx(1'b0, 1'b0);
        tx_beat = 1'b1;
        lrq_ready = 1'b1;
        @(negedge clk);
        check("R6 mem request valid", lrq_valid, 1);
        check("R6 mem request len", lrq_len, 16);
        check("R6 mem request not continuous", lrq_cont, 0);
        check("R5 no ready before request", tgt_ready, 0);
        tick();
        lrq_ready = 1'b0;
        @(negedge clk);
        check("R5 no ready on empty read FIFO", tgt_ready, 0);
        tick();
        rf_level = RLW'(3);
        cnt_a = 0;
        for (int j = 0; j < 16; j++) begin
            @(negedge clk);
            cnt_a += int'(tgt_ready && rf_pop);
            tick();
        end
        check("R5 sixteen ready with pop", cnt_a, 16);
        @(negedge clk);
        check("R6 refill request after 16", lrq_valid, 1);
        check("R6 no ready before refill", tgt_ready, 0);
        tick();
        tx_beat = 1'b0;
        tx_end = 1'b1;
        @(negedge clk);
        check("R9 discard at read end", rd_discard, 1);
        tick();
        tx_end = 1'b0;
        rf_level = '0;

        // Continuous prefetch (R6 R9).
        cfg_cont_pf = 1'b1;
        start_tx(1'b0, 1'b0);
        tx_beat = 1'b1;
        lrq_ready = 1'b1;
        @(negedge clk);
        check("R6 continuous flag", lrq_cont, 1);
        tick();
        lrq_ready = 1'b0;
        rf_level = RLW'(2);
        cnt_a = 0;
        cnt_b = 0;
        for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            cnt_a += int'(tgt_ready);
            cnt_b += int'(lrq_valid);
            tick();
        end
        check("R6 continuous readies", cnt_a, 20);
        check("R6 continuous no refill", cnt_b, 0);
        tx_beat = 1'b0;
        tx_end = 1'b1;
        @(negedge clk);
        check("R9 discard at continuous end", rd_discard, 1);
        tick();
        tx_end = 1'b0;
        rf_level = '0;
        cfg_cont_pf = 1'b0;

        // I/O read: one local cycle per phase (R7).
        cfg_cont_pf = 1'b1;
        start_tx(1'b0, 1'b1);
        cfg_cont_pf = 1'b0;
        tx_beat = 1'b1;
        lrq_ready = 1'b1;
        @(negedge clk);
        check("R7 io request len", lrq_len, 1);
        check("R7 io request not continuous", lrq_cont, 0);
        tick();
        lrq_ready = 1'b0;
        rf_level = RLW'(1);
        @(negedge clk);
        check("R7 io first phase ready", tgt_ready, 1);
        tick();
        @(negedge clk);
        check("R7 io second phase new request", lrq_valid, 1);
        check("R7 io second phase len", lrq_len, 1);
        check("R7 io no ready without request", tgt_ready, 0);
        tick();
        end_tx();
        rf_level = '0;

        // Read timeout and fresh restart (R8 R9).
        cfg_wait_limit = 8'd3;
        start_tx(1'b0, 1'b0);
        tx_beat = 1'b1;
        lrq_ready = 1'b1;
        k = 0;
        got = 1'b0;
        pushed = 1'b0;
        while (!got && k < 40) begin
            @(negedge clk);
            if (tgt_retry) begin
                got = 1'b1;
                pushed = rd_discard;
            end else begin
                tick();
                lrq_ready = 1'b0;
                k++;
            end
        end
        check("R8 read retry cycle", k, 3);
        check("R9 discard on read retry", pushed, 1);
        tick();
        tx_beat = 1'b0;
        rf_level = RLW'(4);
        cfg_wait_limit = 8'd200;
        start_tx(1'b0, 1'b0);
        tx_beat = 1'b1;
        @(negedge clk);
        check("R9 fresh request after retry", lrq_valid, 1);
        check("R9 stale data not used", tgt_ready, 0);
        tick();
        end_tx();
        rf_level = '0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule